// File: doc/BRIEF.md
# Strobe-Held One-of-Sixteen Line Selector

This block turns a 4-bit address into a one-of-sixteen select word. A strobe input lets the address pass straight through to the decoder while it is high. When the strobe goes low, the block keeps the last address it saw. In this synchronous version, the holding stage is a register that loads on every clock edge at which the strobe is high. While the strobe is high, a bypass path makes the output follow the live address in the same cycle.

An inhibit input forces every output line to its inactive level. It does not disturb the held address, so the earlier selection comes back as soon as inhibit is released. A parameter picks the output polarity. In the high-active variant the chosen line is 1 and the rest are 0. In the low-active variant the whole word is inverted. A synchronous reset clears the held address to zero.

Top module: `strobe_decoder`

## Requirements
- R1: While `stb` is 1, the selected line index equals the present value of `addr_in` in the same cycle, with no clock delay.
- R2: After `stb` falls, the selection equals the `addr_in` value sampled at the last rising clock edge at which `stb` was 1.
- R3: While `stb` stays 0, changes on `addr_in` do not change `sel_out`.
- R4: The selected line is `sel_out[n]`, where n is `addr_in` read as an unsigned binary number with `addr_in[0]` as the least significant bit.
- R5: While `inh` is 1, every bit of `sel_out` is at its inactive level, whatever `addr_in` and `stb` are.
- R6: With `POL` = POL_HIGH, exactly one output bit is 1 and the others are 0. With `POL` = POL_LOW, exactly one bit is 0 and the others are 1. Under inhibit, every bit is 0 in the first variant and 1 in the second.
- R7: Inhibit does not change the held address. A capture made while `inh` is 1 still takes effect. When `inh` returns to 0, the held selection appears in the same cycle.
- R8: A clock edge with `rst` at 1 clears the held address to 0. With `stb` and `inh` both 0 afterwards, line 0 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the held address |
| addr_in | input | 4 | Address to decode, bit 0 least significant |
| stb | input | 1 | 1: address passes through and is loaded each edge; 0: hold |
| inh | input | 1 | 1: force all outputs inactive |
| sel_out | output | 16 | One-of-sixteen select word, polarity set by `POL` |

## Verification
The assertions assume that `addr_in`, `stb` and `inh` change only away from the rising clock edge. They also assume that the address is stable at the edge of the last strobe-high cycle, which is the synchronous form of the setup rule before strobe falls. The capture and hold properties take the value sampled at that edge as the one held. The bench drives every input on the falling clock edge, so each capture edge sees settled data. It samples outputs one time unit later, after the bypass path and the output stage have settled.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  typedef enum logic {POL_HIGH = 1'b0, POL_LOW = 1'b1} pol_e;
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] eff
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (load) held_q <= d;
  end

  // transparent while load is high, held value otherwise
  assign eff = load ? d : held_q;
endmodule

// File: rtl/line_decode.sv
module line_decode #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] addr,
  output logic [N-1:0] hot
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot[i] = (addr == W'(i));
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int N = 16,
  parameter sdec_pkg::pol_e POL = sdec_pkg::POL_HIGH
) (
  input  logic [N-1:0] hot,
  input  logic         inh,
  output logic [N-1:0] sel
);
  logic [N-1:0] gated;
  assign gated = hot & {N{~inh}};

  if (POL == sdec_pkg::POL_LOW) begin : g_low
    assign sel = ~gated;
  end else begin : g_high
    assign sel = gated;
  end
endmodule

// File: rtl/strobe_decoder.sv
module strobe_decoder #(
  parameter int ADDR_W = 4,
  parameter sdec_pkg::pol_e POL = sdec_pkg::POL_HIGH,
  localparam int LINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              stb,
  input  logic              inh,
  output logic [LINES-1:0]  sel_out
);
  logic [ADDR_W-1:0] addr_eff;
  logic [LINES-1:0]  hot;

  addr_hold #(.W(ADDR_W)) u_hold (
    .clk (clk), .rst (rst), .load (stb), .d (addr_in), .eff (addr_eff)
  );

  line_decode #(.W(ADDR_W)) u_dec (
    .addr (addr_eff), .hot (hot)
  );

  out_stage #(.N(LINES), .POL(POL)) u_out (
    .hot (hot), .inh (inh), .sel (sel_out)
  );
endmodule

// File: rtl/strobe_decoder_chk.sv
module strobe_decoder_chk #(
  parameter int ADDR_W = 4,
  parameter sdec_pkg::pol_e POL = sdec_pkg::POL_HIGH,
  localparam int LINES = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              stb,
  input logic              inh,
  input logic [LINES-1:0]  sel_out
);
  localparam logic ACT = (POL == sdec_pkg::POL_LOW) ? 1'b0 : 1'b1;
  localparam logic [LINES-1:0] IDLE = {LINES{~ACT}};

  assert_inhibit_idle_R5: assert property (@(posedge clk) disable iff (rst)
    inh |-> (sel_out == IDLE));

  assert_single_active_R6: assert property (@(posedge clk) disable iff (rst)
    !inh |-> ($countones(sel_out ^ IDLE) == 1));

  assert_follow_R1: assert property (@(posedge clk) disable iff (rst)
    (stb && !inh) |-> (sel_out[addr_in] == ACT));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(stb) && !stb && !inh && !$past(rst)) |-> (sel_out[$past(addr_in)] == ACT));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!stb && !$past(stb) && !inh && !$past(inh) && !$past(rst)) |-> $stable(sel_out));

  assert_reset_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !stb && !inh) |-> (sel_out[0] == ACT));
endmodule

bind strobe_decoder strobe_decoder_chk #(.ADDR_W(ADDR_W), .POL(POL)) u_chk (
  .clk (clk), .rst (rst), .addr_in (addr_in), .stb (stb), .inh (inh), .sel_out (sel_out)
);

// File: tb/tb_strobe_decoder.sv
module tb_strobe_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr_in = '0;
  logic        stb = 1'b0;
  logic        inh = 1'b0;
  logic [15:0] sel_hi, sel_lo;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_decoder #(.POL(sdec_pkg::POL_HIGH)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .stb(stb), .inh(inh), .sel_out(sel_hi));
  strobe_decoder #(.POL(sdec_pkg::POL_LOW)) dut_lo (
    .clk(clk), .rst(rst), .addr_in(addr_in), .stb(stb), .inh(inh), .sel_out(sel_lo));

  // {addr[4], stb, inh, expected index[5]}; index 16 means no line active
  localparam logic [10:0] VEC [8] = '{
    {4'd5,  1'b1, 1'b0, 5'd5},   // R1 pass-through
    {4'd9,  1'b0, 1'b0, 5'd5},   // R3 ignored while held
    {4'd3,  1'b0, 1'b1, 5'd16},  // R5 inhibit
    {4'd3,  1'b0, 1'b0, 5'd5},   // R7 release
    {4'd15, 1'b1, 1'b1, 5'd16},  // R5 inhibit with strobe high
    {4'd0,  1'b0, 1'b0, 5'd15},  // R2 capture under inhibit kept
    {4'd0,  1'b1, 1'b0, 5'd0},   // R4 line 0
    {4'd12, 1'b0, 1'b0, 5'd0}    // R3 ignored while held
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1"; 1: return "R3"; 2: return "R5"; 3: return "R7";
      4: return "R5"; 5: return "R2"; 6: return "R4"; default: return "R3";
    endcase
  endfunction

  function automatic logic [15:0] expect_word(int idx, bit low);
    logic [15:0] w = '0;
    if (idx < 16) w[idx] = 1'b1;
    return low ? ~w : w;
  endfunction

  // R6: both polarity variants compared every time
  task automatic check(string req, int idx);
    logic [15:0] eh = expect_word(idx, 1'b0);
    logic [15:0] el = expect_word(idx, 1'b1);
    checks++;
    if (sel_hi !== eh) begin
      errors++;
      $display("FAIL %s high-active: actual=%h expected=%h", req, sel_hi, eh);
    end
    checks++;
    if (sel_lo !== el) begin
      errors++;
      $display("FAIL %s low-active: actual=%h expected=%h", req, sel_lo, el);
    end
  endtask

  task automatic drive(logic [3:0] a, logic s, logic i);
    @(negedge clk);
    addr_in = a; stb = s; inh = i;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", 0);

    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][10:7], VEC[i][6], VEC[i][5]);
      check(vec_tag(i), int'(VEC[i][4:0]));
    end

    // sweep all addresses: transparent, then held against changed data
    for (int a = 0; a < 16; a++) begin
      drive(4'(a), 1'b1, 1'b0);
      check("R4", a);
      drive(~4'(a), 1'b0, 1'b0);
      check("R2", a);
    end

    // inhibit leaves held address alone (held = 15)
    drive(4'd2, 1'b0, 1'b1);
    check("R5", NONE);
    drive(4'd2, 1'b0, 1'b0);
    check("R7", 15);

    // reset clears held address
    drive(4'd7, 1'b1, 1'b0);
    check("R1", 7);
    @(negedge clk);
    rst = 1'b1; stb = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule